// File: doc/BRIEF.md
# Passive Serial Configuration Loader

This block loads a configuration bitstream into a programmable target device over a three-wire passive serial link. A start strobe, sampled together with a total byte count, begins the load. The block first runs a timed reset handshake: it holds the target's active-low configuration request low for a fixed time, confirms that the target's active-low status line has gone low, releases the request, waits a settle time, and then polls until the status line goes high again. Polling has a bounded timeout. Bytes then arrive on a valid/ready stream. Each byte is shifted out least significant bit first. For every bit the serial clock is low while the data bit is presented, and the target samples on the rising edge.

After the last byte the block checks the target's configuration-done input. If it is high, the block gives a fixed number of trailing clock pulses (high, then low) and reports success. Any failure, or an external abort request, sends the controller through a one-cycle abort state that releases the link. It leaves a distinct error code, which stays until the next start. All delays, the timeout and the serial clock half-period are parameters counted in system clock cycles.

States and transitions:
- IDLE goes to HOLD on start.
- HOLD goes to SETTLE when the hold timer expires with status low. It goes to ABORT when status is still high.
- SETTLE goes to POLL when the settle timer expires.
- POLL goes to STREAM, or to CHECK when the byte count is zero, once status reads high. It goes to ABORT on timeout.
- STREAM goes to CHECK when no bytes remain and the shifter is empty.
- CHECK goes to TRAIL when configuration-done is high, and to ABORT otherwise.
- TRAIL goes to IDLE, with success, when the trailing pulses finish.
- ABORT always goes to IDLE.
- From HOLD, SETTLE, POLL, STREAM, CHECK and TRAIL, an abort request goes to ABORT.

Top module: `pscfg_loader`

## Requirements
- R1: After reset, cfg_n is 1, sclk is 0, sdata is 0, busy is 0, s_ready is 0, ok is 0 and err_code is 0.
- R2: A start in IDLE drives cfg_n low for exactly HOLD_CYC cycles, beginning the cycle after the start.
- R3: If status_n is high on the last cycle of the hold, the load ends with err_code 1 and no sclk pulse is given.
- R4: After cfg_n rises there are SETTLE_CYC settle cycles and then up to TIMEOUT_CYC poll cycles. If status_n stays low through the whole poll window, the load ends with err_code 2 after one abort cycle, so busy is high with cfg_n high for SETTLE_CYC+TIMEOUT_CYC+1 cycles.
- R5: Each byte gives 8 sclk pulses, least significant bit first. Each pulse is HALF_CYC cycles low and then HALF_CYC cycles high. sdata holds steady while sclk is high, so the value at each rising edge is the bit.
- R6: s_ready is high only while streaming, with the shifter empty and bytes remaining. Exactly byte_count bytes are accepted.
- R7: If conf_done is low when checked after the last byte, the load ends with err_code 3 and no trailing pulses.
- R8: If conf_done is high, TRAIL_PULSES more sclk pulses (high first) follow. Then ok is 1, err_code is 0 and busy is 0.
- R9: abort_req while busy ends the load with err_code 4 and stops further sclk pulses. It leaves cfg_n at 1 and sclk at 0.
- R10: err_code and ok keep their values while idle until the next start, which clears both.
- R11: A start while busy is ignored. The running load keeps its byte count and does not restart the hold.
- R12: A byte count of 0 skips streaming and goes straight to the conf_done check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, one cycle |
| byte_count | input | CNT_W | Number of bytes to load, sampled with start |
| abort_req | input | 1 | External abort request |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_ready | output | 1 | Stream byte accepted when high with s_valid |
| cfg_n | output | 1 | Active-low configuration request to the target |
| sclk | output | 1 | Serial configuration clock |
| sdata | output | 1 | Serial configuration data |
| status_n | input | 1 | Active-low status from the target |
| conf_done | input | 1 | Configuration-done from the target |
| busy | output | 1 | Load in progress |
| ok | output | 1 | Last load succeeded |
| err_code | output | 3 | 0 none, 1 status not asserted, 2 status release timeout, 3 conf_done missing, 4 aborted |

## Verification
The assertions check four things on every cycle:
- sdata never changes while sclk stays high;
- the shifter is loaded only when empty, and s_ready only appears with busy high and cfg_n released;
- an idle controller leaves sclk low and cfg_n high, success never coexists with an error code, and the error code is frozen while idle;
- the handshake timer counts down by one per cycle.

Only the bench scenarios can show the rest: the bit order and byte content across all 256 byte values, the exact hold and timeout lengths, the trailing pulse count, and the outcome of each failure path, of an abort or a second start mid-load, and of a zero-length load.

// File: rtl/pscfg_pkg.sv
package pscfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_HOLD   = 3'd1,
        ST_SETTLE = 3'd2,
        ST_POLL   = 3'd3,
        ST_STREAM = 3'd4,
        ST_CHECK  = 3'd5,
        ST_TRAIL  = 3'd6,
        ST_ABORT  = 3'd7
    } ld_state_t;

    typedef enum logic [2:0] {
        E_NONE     = 3'd0,
        E_NOSTAT   = 3'd1,
        E_TIMEOUT  = 3'd2,
        E_NODONE   = 3'd3,
        E_ABORTED  = 3'd4
    } ld_err_t;

    function automatic int bits_for(input int value);
        int n;
        n = 1;
        while ((1 << n) <= value) n++;
        return n;
    endfunction

endpackage

// File: rtl/pscfg_timer.sv
module pscfg_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         done
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

    AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4

endmodule

// File: rtl/pscfg_serial.sv
module pscfg_serial #(
    parameter int HALF_CYC     = 2,
    parameter int TRAIL_PULSES = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_byte,
    input  logic [7:0] byte_in,
    input  logic       load_trail,
    input  logic       flush,
    output logic       sclk,
    output logic       sdata,
    output logic       idle
);
    import pscfg_pkg::*;

    localparam int HW     = bits_for(HALF_CYC);
    localparam int PMAX   = (TRAIL_PULSES > 8) ? TRAIL_PULSES : 8;
    localparam int PW     = bits_for(PMAX);

    logic          active_q;
    logic          trail_q;
    logic          second_q;
    logic [HW-1:0] half_q;
    logic [PW-1:0] left_q;
    logic [7:0]    sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            trail_q  <= 1'b0;
            second_q <= 1'b0;
            half_q   <= '0;
            left_q   <= '0;
            sh_q     <= '0;
        end else if (flush) begin
            active_q <= 1'b0;
            trail_q  <= 1'b0;
            second_q <= 1'b0;
            sh_q     <= '0;
        end else if (load_byte) begin
            active_q <= 1'b1;
            trail_q  <= 1'b0;
            second_q <= 1'b0;
            half_q   <= HW'(HALF_CYC - 1);
            left_q   <= PW'(7);
            sh_q     <= byte_in;
        end else if (load_trail) begin
            active_q <= 1'b1;
            trail_q  <= 1'b1;
            second_q <= 1'b0;
            half_q   <= HW'(HALF_CYC - 1);
            left_q   <= PW'(TRAIL_PULSES - 1);
            sh_q     <= '0;
        end else if (active_q) begin
            if (half_q != '0) begin
                half_q <= half_q - 1'b1;
            end else begin
                half_q <= HW'(HALF_CYC - 1);
                if (!second_q) begin
                    second_q <= 1'b1;
                end else begin
                    second_q <= 1'b0;
                    if (left_q == '0) begin
                        active_q <= 1'b0;
                        sh_q     <= '0;
                    end else begin
                        left_q <= left_q - 1'b1;
                        sh_q   <= {1'b0, sh_q[7:1]};
                    end
                end
            end
        end
    end

    // byte pulses: low phase then high phase; trailing pulses: high then low
    assign sclk  = active_q && (trail_q ? !second_q : second_q);
    assign sdata = active_q && !trail_q && sh_q[0];
    assign idle  = !active_q;

    AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdata)); // R5
    AST_LOAD_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (load_byte || load_trail) |-> idle); // R6

endmodule

// File: rtl/pscfg_seq.sv
module pscfg_seq #(
    parameter int HOLD_CYC     = 250,
    parameter int SETTLE_CYC   = 250,
    parameter int TIMEOUT_CYC  = 1000,
    parameter int CNT_W        = 16,
    parameter int TW           = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] byte_count,
    input  logic             abort_req,
    input  logic             s_valid,
    output logic             s_ready,
    input  logic             status_n,
    input  logic             conf_done,
    input  logic             tmr_done,
    output logic             tmr_load,
    output logic [TW-1:0]    tmr_val,
    input  logic             eng_idle,
    output logic             eng_load_byte,
    output logic             eng_load_trail,
    output logic             eng_flush,
    output logic             cfg_n,
    output logic             busy,
    output logic             ok,
    output logic [2:0]       err_code
);
    import pscfg_pkg::*;

    ld_state_t        state_q, state_d;
    ld_err_t          err_q, err_d;
    logic             ok_q, ok_d;
    logic [CNT_W-1:0] rem_q, rem_d;
    logic             accept;

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            err_q   <= E_NONE;
            ok_q    <= 1'b0;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
            ok_q    <= ok_d;
            rem_q   <= rem_d;
        end
    end

    // next state, timer and shifter control
    always_comb begin
        state_d        = state_q;
        err_d          = err_q;
        ok_d           = ok_q;
        rem_d          = rem_q;
        tmr_load       = 1'b0;
        tmr_val        = '0;
        eng_load_trail = 1'b0;
        eng_flush      = 1'b0;

        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d  = ST_HOLD;
                    err_d    = E_NONE;
                    ok_d     = 1'b0;
                    rem_d    = byte_count;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(HOLD_CYC - 1);
                end
            end
            ST_HOLD: begin
                if (tmr_done) begin
                    if (!status_n) begin
                        state_d  = ST_SETTLE;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(SETTLE_CYC - 1);
                    end else begin
                        state_d = ST_ABORT;
                        err_d   = E_NOSTAT;
                    end
                end
            end
            ST_SETTLE: begin
                if (tmr_done) begin
                    state_d  = ST_POLL;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(TIMEOUT_CYC - 1);
                end
            end
            ST_POLL: begin
                if (status_n) begin
                    state_d = (rem_q == '0) ? ST_CHECK : ST_STREAM;
                end else if (tmr_done) begin
                    state_d = ST_ABORT;
                    err_d   = E_TIMEOUT;
                end
            end
            ST_STREAM: begin
                if (accept) begin
                    rem_d = rem_q - 1'b1;
                end
                if (rem_q == '0 && eng_idle) begin
                    state_d = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (conf_done) begin
                    state_d        = ST_TRAIL;
                    eng_load_trail = 1'b1;
                end else begin
                    state_d = ST_ABORT;
                    err_d   = E_NODONE;
                end
            end
            ST_TRAIL: begin
                if (eng_idle) begin
                    state_d = ST_IDLE;
                    ok_d    = 1'b1;
                end
            end
            ST_ABORT: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase

        if (abort_req && state_q != ST_IDLE && state_q != ST_ABORT) begin
            state_d        = ST_ABORT;
            err_d          = E_ABORTED;
            ok_d           = 1'b0;
            eng_load_trail = 1'b0;
        end
        if (state_d == ST_ABORT && state_q != ST_ABORT) begin
            eng_flush = 1'b1;
        end
    end

    // output process
    always_comb begin
        cfg_n         = (state_q != ST_HOLD);
        busy          = (state_q != ST_IDLE);
        s_ready       = (state_q == ST_STREAM) && eng_idle && (rem_q != '0);
        accept        = s_ready && s_valid;
        eng_load_byte = accept && !eng_flush;
        ok            = ok_q;
        err_code      = err_q;
    end

    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STREAM && start && !abort_req) |=> (state_q != ST_HOLD)); // R11
    AST_COUNT_NOT_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STREAM && rem_q == '0) |=> (rem_q == '0)); // R6

endmodule

// File: rtl/pscfg_loader.sv
module pscfg_loader #(
    parameter int HOLD_CYC     = 250,
    parameter int SETTLE_CYC   = 250,
    parameter int TIMEOUT_CYC  = 12_500_000,
    parameter int HALF_CYC     = 2,
    parameter int TRAIL_PULSES = 12,
    parameter int CNT_W        = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] byte_count,
    input  logic             abort_req,
    input  logic             s_valid,
    input  logic [7:0]       s_data,
    output logic             s_ready,
    output logic             cfg_n,
    output logic             sclk,
    output logic             sdata,
    input  logic             status_n,
    input  logic             conf_done,
    output logic             busy,
    output logic             ok,
    output logic [2:0]       err_code
);
    import pscfg_pkg::*;

    localparam int TMAX_A = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
    localparam int TMAX   = (TMAX_A > TIMEOUT_CYC) ? TMAX_A : TIMEOUT_CYC;
    localparam int TW     = bits_for(TMAX);

    logic          tmr_load, tmr_done;
    logic [TW-1:0] tmr_val;
    logic          eng_idle, eng_load_byte, eng_load_trail, eng_flush;

    pscfg_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .val   (tmr_val),
        .done  (tmr_done)
    );

    pscfg_serial #(
        .HALF_CYC     (HALF_CYC),
        .TRAIL_PULSES (TRAIL_PULSES)
    ) u_serial (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_byte  (eng_load_byte),
        .byte_in    (s_data),
        .load_trail (eng_load_trail),
        .flush      (eng_flush),
        .sclk       (sclk),
        .sdata      (sdata),
        .idle       (eng_idle)
    );

    pscfg_seq #(
        .HOLD_CYC    (HOLD_CYC),
        .SETTLE_CYC  (SETTLE_CYC),
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .CNT_W       (CNT_W),
        .TW          (TW)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .byte_count     (byte_count),
        .abort_req      (abort_req),
        .s_valid        (s_valid),
        .s_ready        (s_ready),
        .status_n       (status_n),
        .conf_done      (conf_done),
        .tmr_done       (tmr_done),
        .tmr_load       (tmr_load),
        .tmr_val        (tmr_val),
        .eng_idle       (eng_idle),
        .eng_load_byte  (eng_load_byte),
        .eng_load_trail (eng_load_trail),
        .eng_flush      (eng_flush),
        .cfg_n          (cfg_n),
        .busy           (busy),
        .ok             (ok),
        .err_code       (err_code)
    );

    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk && cfg_n)); // R9
    AST_OK_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> (err_code == 3'd0)); // R8
    AST_ERR_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && !$past(start)) |-> ($stable(err_code) && $stable(ok))); // R10
    AST_READY_STREAM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> (busy && cfg_n)); // R6

endmodule

// File: tb/tb_pscfg_loader.sv
module tb_pscfg_loader;

    localparam int HOLD    = 4;
    localparam int SETTLE  = 3;
    localparam int TMO     = 20;
    localparam int HALF    = 2;
    localparam int TRAIL   = 12;
    localparam int CW      = 9;
    localparam int REL_DLY = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] byte_count = '0;
    logic          abort_req = 1'b0;
    logic          s_valid = 1'b0;
    logic [7:0]    s_data = '0;
    logic          s_ready, cfg_n, sclk, sdata, busy, ok;
    logic          status_n = 1'b1;
    logic          conf_done = 1'b0;
    logic [2:0]    err_code;

    always #4 clk = ~clk;

    pscfg_loader #(
        .HOLD_CYC (HOLD), .SETTLE_CYC (SETTLE), .TIMEOUT_CYC (TMO),
        .HALF_CYC (HALF), .TRAIL_PULSES (TRAIL), .CNT_W (CW)
    ) dut (
        .clk (clk), .rst_n (rst_n), .start (start), .byte_count (byte_count),
        .abort_req (abort_req), .s_valid (s_valid), .s_data (s_data),
        .s_ready (s_ready), .cfg_n (cfg_n), .sclk (sclk), .sdata (sdata),
        .status_n (status_n), .conf_done (conf_done), .busy (busy), .ok (ok),
        .err_code (err_code)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit cond, input string req, input int act, input int exp);
        n_checks++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // stimulus state shared with the target model and stream source
    logic [7:0] mem [256];
    logic [7:0] rx  [256];
    int  feed_n = 0;
    int  idx = 0;
    bit  acc_pend = 1'b0;
    int  smode = 0;      // 0 normal, 1 status stuck high, 2 status stuck low
    bit  cd_en = 1'b0;
    int  rel = 0;
    int  rises = 0;
    int  cfg_low = 0;
    int  hi_busy = 0;
    int  bad_ready = 0;
    bit  prev_sclk = 1'b0;

    // target device model and byte source, both acting on the falling edge
    always @(negedge clk) begin
        if (acc_pend) idx++;
        s_valid  = (idx < feed_n);
        s_data   = mem[idx[7:0]];
        acc_pend = s_valid && s_ready;

        case (smode)
            1: status_n = 1'b1;
            2: status_n = 1'b0;
            default: begin
                if (!cfg_n) begin
                    status_n = 1'b0;
                    rel = 0;
                end else if (rel < REL_DLY) begin
                    rel++;
                end else begin
                    status_n = 1'b1;
                end
            end
        endcase
        conf_done = cd_en && (idx >= feed_n) && cfg_n;
    end

    // link monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk && !prev_sclk) begin
                if (rises < 8 * feed_n && rises < 2048)
                    rx[rises / 8][rises % 8] = sdata;
                rises++;
            end
            if (!cfg_n) cfg_low++;
            if (busy && cfg_n) hi_busy++;
            if (s_ready && !cfg_n) bad_ready++;
        end
        prev_sclk = sclk;
    end

    int err_early;

    task automatic do_load(input int n, input int mode, input bit cd,
                           input int abort_at, input int restart_at);
        int cyc;
        feed_n = n; idx = 0; acc_pend = 1'b0;
        smode = mode; cd_en = cd;
        rises = 0; cfg_low = 0; hi_busy = 0; bad_ready = 0;
        for (int i = 0; i < 256; i++) rx[i] = 8'h00;
        @(negedge clk);
        start = 1'b1; byte_count = CW'(n);
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        err_early = err_code;
        while (busy && cyc < 20000) begin
            abort_req = (cyc == abort_at);
            if (cyc == restart_at) begin
                start = 1'b1; byte_count = CW'(7);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        abort_req = 1'b0; start = 1'b0;
        check(cyc < 20000, "R2 load finished", cyc, 20000);
        @(negedge clk);
    endtask

    task automatic check_success(input int n, input string tag);
        check(err_code == 3'd0, {tag, " R8 err"}, err_code, 0);
        check(ok == 1'b1, {tag, " R8 ok"}, ok, 1);
        check(busy == 1'b0, {tag, " R8 busy"}, busy, 0);
        check(rises == 8 * n + TRAIL, {tag, " R8 pulse count"}, rises, 8 * n + TRAIL);
        check(idx == n, {tag, " R6 bytes accepted"}, idx, n);
        check(cfg_low == HOLD, {tag, " R2 hold length"}, cfg_low, HOLD);
        check(bad_ready == 0, {tag, " R6 ready outside stream"}, bad_ready, 0);
        for (int i = 0; i < n; i++)
            check(rx[i] == mem[i], {tag, " R5 byte LSB first"}, rx[i], mem[i]);
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cfg_n == 1'b1, "R1 cfg_n", cfg_n, 1);
        check(sclk == 1'b0, "R1 sclk", sclk, 0);
        check(sdata == 1'b0, "R1 sdata", sdata, 0);
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(s_ready == 1'b0, "R1 s_ready", s_ready, 0);
        check(ok == 1'b0, "R1 ok", ok, 0);
        check(err_code == 3'd0, "R1 err_code", err_code, 0);

        // R5 exhaustive sweep of all 256 byte values in one load
        for (int i = 0; i < 256; i++) mem[i] = 8'(i);
        do_load(256, 0, 1'b1, -1, -1);
        check_success(256, "sweep");

        // short loads with arithmetic patterns
        for (int len = 1; len <= 5; len++) begin
            for (int i = 0; i < len; i++) mem[i] = 8'((i * 37 + len * 11) ^ 8'hA5);
            do_load(len, 0, 1'b1, -1, -1);
            check_success(len, "short");
        end

        // R12 zero-length load
        do_load(0, 0, 1'b1, -1, -1);
        check_success(0, "R12 zero");

        // R3 status never asserted
        do_load(2, 1, 1'b1, -1, -1);
        check(err_code == 3'd1, "R3 err_code", err_code, 1);
        check(rises == 0, "R3 no pulses", rises, 0);
        check(ok == 1'b0, "R3 ok", ok, 0);

        // R4 status release timeout
        do_load(2, 2, 1'b1, -1, -1);
        check(err_code == 3'd2, "R4 err_code", err_code, 2);
        check(hi_busy == SETTLE + TMO + 1, "R4 settle+poll window", hi_busy, SETTLE + TMO + 1);
        check(rises == 0, "R4 no pulses", rises, 0);

        // R10 error held while idle
        repeat (10) @(negedge clk);
        check(err_code == 3'd2, "R10 err held", err_code, 2);

        // R7 conf_done missing
        for (int i = 0; i < 3; i++) mem[i] = 8'(8'h3C + i);
        do_load(3, 0, 1'b0, -1, -1);
        check(err_early == 0, "R10 start clears err", err_early, 0);
        check(err_code == 3'd3, "R7 err_code", err_code, 3);
        check(rises == 24, "R7 no trailing pulses", rises, 24);
        for (int i = 0; i < 3; i++)
            check(rx[i] == mem[i], "R7 bytes sent", rx[i], mem[i]);

        // R9 abort mid-stream
        for (int i = 0; i < 4; i++) mem[i] = 8'(8'hF0 - i * 3);
        do_load(4, 0, 1'b1, 60, -1);
        check(err_code == 3'd4, "R9 err_code", err_code, 4);
        check(rises < 32, "R9 pulses stopped", rises, 31);
        check(cfg_n == 1'b1, "R9 cfg_n released", cfg_n, 1);
        check(sclk == 1'b0, "R9 sclk low", sclk, 0);
        check(ok == 1'b0, "R9 ok", ok, 0);
        repeat (6) @(negedge clk);
        check(rises < 32 && sclk == 1'b0, "R9 no later pulses", rises, 31);

        // R11 start while busy ignored
        for (int i = 0; i < 3; i++) mem[i] = 8'(8'h5A + i * 19);
        do_load(3, 0, 1'b1, -1, 40);
        check(err_early == 0, "R10 start clears abort code", err_early, 0);
        check_success(3, "R11 restart ignored");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule